// File: doc/BRIEF.md
# Split-Transaction Bus Requester

This block is the master side of one card on a shared synchronous bus. The bus has a 32-bit data path and 4-bit slot numbers. The card's local logic presents one request at a time. A request is either a write (a command word followed by a data word) or a read (a command word only, answered later by a one- or two-word response). The block asks the arbiter for the bus and holds the request until it is granted. It then spends one cycle naming the destination slot and its own slot, and then drives the command beat and any write data beat. Every byte it puts on the bus carries its own parity bit.

A target that cannot take the command raises NACK in the command cycle and returns a 4-bit callback number. The block keeps the request under that number and ignores the local interface. It waits for a callback address phase from the rejecting slot that carries the same number, and in the next cycle it replays the command and any data word. For reads, the block watches for a response address phase aimed at its own slot from the slot it addressed. It then takes one or two data beats, checks their parity and passes good beats to local logic. A counter limits how long it waits for a response.

Top module: `sbr_requester`

## Requirements
- R1: After reset, req_ready is 1 and arb_req, addr_drv, data_drv, resp_valid, par_err and timeout_err are all 0.
- R2: A request is taken at a clock edge where req_valid and req_ready are both 1. req_ready then stays 0 until the transaction ends: the write data beat has been driven, the last response beat has been taken, or the timeout has fired.
- R3: arb_req is 1 from the cycle after acceptance until the cycle in which arb_grant is sampled as 1. In the next cycle addr_drv is 1, addr_slot_out carries the destination slot and addr_src_out carries my_slot.
- R4: The cycle after the address cycle drives data_out with the command word. For a write, the following cycle drives the write data word, and the block is idle one cycle after that. data_drv is 1 exactly in those cycles.
- R5: Parity is odd per byte: par_out[i] makes data_out[8i+7:8i] plus that bit hold an odd number of ones, with lane 0 on bits 7:0. This holds whenever data_drv is 1.
- R6: If bus_nack is 1 in the command cycle, bus_cb_num is stored. No write data beat follows, nothing is driven, and req_ready stays 0.
- R7: While waiting after a rejection, an address phase with bus_addr_valid=1, bus_addr_cb=1, bus_addr_src equal to the stored destination and bus_addr_slot equal to the stored callback number causes the original command to be replayed in the next cycle, followed by the original write data for a write. An address phase that differs in source or number causes no bus activity.
- R8: While waiting for a read response, an address phase with bus_addr_valid=1, bus_addr_cb=0, bus_addr_slot equal to my_slot and bus_addr_src equal to the destination is followed by one data beat (req_double=0) or two (req_double=1). Each good beat appears on resp_data with resp_valid=1 one cycle after it is on the bus. Other address phases cause no response.
- R9: A received beat whose parity is not odd in some byte gives par_err=1 one cycle later and resp_valid=0 for that beat.
- R10: If no matching response address phase arrives within TIMEOUT_CYC cycles of entering the response wait, timeout_err pulses for one cycle, and in that same cycle req_ready returns to 1.
- R11: req_valid while req_ready is 0 is ignored: a later replay drives the first request's words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_slot | input | 4 | This card's slot number |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_double | input | 1 | Read expects two response words |
| req_dest | input | 4 | Destination slot |
| req_cmd | input | 32 | Command word (operation and memory address) |
| req_wdata | input | 32 | Write data word |
| arb_req | output | 1 | Bus request to the arbiter |
| arb_grant | input | 1 | Arbiter grant for this card |
| addr_drv | output | 1 | Address phase driven this cycle |
| addr_slot_out | output | 4 | Destination slot in address phase |
| addr_src_out | output | 4 | Source slot in address phase |
| data_drv | output | 1 | Data phase driven this cycle |
| data_out | output | 32 | Data beat driven |
| par_out | output | 4 | Odd parity per byte of data_out |
| bus_nack | input | 1 | Wired-OR NACK from target |
| bus_cb_num | input | 4 | Callback number returned with NACK |
| bus_addr_valid | input | 1 | Some card drives an address phase |
| bus_addr_cb | input | 1 | Address phase is a callback |
| bus_addr_slot | input | 4 | Slot or callback number on the bus |
| bus_addr_src | input | 4 | Source slot of the address phase |
| bus_data_in | input | 32 | Data beat seen on the bus |
| bus_par_in | input | 4 | Parity bits seen on the bus |
| resp_valid | output | 1 | Good response word present |
| resp_data | output | 32 | Response word |
| par_err | output | 1 | Received beat failed parity |
| timeout_err | output | 1 | Read response never arrived |

## Verification
Outputs are Moore-style, so each bus result is due a fixed number of edges after its cause. Acceptance is followed one edge later by arb_req, a sampled grant by the address cycle one edge later, then the command beat, then the write data beat. A matching callback address is followed one edge later by the replayed command. A received beat shows up on resp_valid or par_err one edge after it is on the bus, and the timeout fires TIMEOUT_CYC edges after the wait begins. The bench drives inputs and samples outputs on the falling edge only, so each check falls in the one half-cycle where the value is due.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARB   = 3'd1,
    ST_ADDR  = 3'd2,
    ST_CMD   = 3'd3,
    ST_WDATA = 3'd4,
    ST_WCB   = 3'd5,
    ST_WRSP  = 3'd6,
    ST_RX    = 3'd7
  } sbr_state_e;
endpackage

// File: rtl/sbr_parity.sv
module sbr_parity #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic [DATA_W-1:0] data,
  output logic [LANES-1:0]  par
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign par[g] = ~(^data[8*g +: 8]);
  end
endmodule

// File: rtl/sbr_timeout.sv
module sbr_timeout #(
  parameter int LIMIT = 1024,
  localparam int CNT_W = $clog2(LIMIT) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = run && (cnt_q == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/sbr_rx.sv
module sbr_rx #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_en,
  input  logic [DATA_W-1:0] beat_data,
  input  logic [LANES-1:0]  beat_par,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic              par_err
);
  logic [LANES-1:0] exp_par;
  logic             good;
  logic             valid_d, err_d;

  sbr_parity #(.DATA_W(DATA_W)) u_chk_par (.data(beat_data), .par(exp_par));

  assign good    = (exp_par == beat_par);
  assign valid_d = beat_en && good;
  assign err_d   = beat_en && !good;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      par_err    <= 1'b0;
    end else begin
      resp_valid <= valid_d;
      par_err    <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       resp_data <= '0;
    else if (valid_d) resp_data <= beat_data;
  end
endmodule

// File: rtl/sbr_requester.sv
module sbr_requester #(
  parameter int DATA_W      = 32,
  parameter int SLOT_W      = 4,
  parameter int CB_W        = 4,
  parameter int TIMEOUT_CYC = 1024,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] my_slot,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_double,
  input  logic [SLOT_W-1:0] req_dest,
  input  logic [DATA_W-1:0] req_cmd,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              arb_req,
  input  logic              arb_grant,
  output logic              addr_drv,
  output logic [SLOT_W-1:0] addr_slot_out,
  output logic [SLOT_W-1:0] addr_src_out,
  output logic              data_drv,
  output logic [DATA_W-1:0] data_out,
  output logic [LANES-1:0]  par_out,
  input  logic              bus_nack,
  input  logic [CB_W-1:0]   bus_cb_num,
  input  logic              bus_addr_valid,
  input  logic              bus_addr_cb,
  input  logic [SLOT_W-1:0] bus_addr_slot,
  input  logic [SLOT_W-1:0] bus_addr_src,
  input  logic [DATA_W-1:0] bus_data_in,
  input  logic [LANES-1:0]  bus_par_in,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic              par_err,
  output logic              timeout_err
);
  import sbr_pkg::*;

  sbr_state_e        state_q, state_d;
  logic              write_q, double_q;
  logic [SLOT_W-1:0] dest_q;
  logic [DATA_W-1:0] cmd_q, wdata_q;
  logic [CB_W-1:0]   cb_q;
  logic              beat_idx_q, beat_idx_d;
  logic              accept, cb_load, expire, tmo_d;
  logic              cb_hit, rsp_hit;

  assign accept  = (state_q == ST_IDLE) && req_valid;
  assign cb_load = (state_q == ST_CMD) && bus_nack;

  assign cb_hit  = bus_addr_valid && bus_addr_cb &&
                   (bus_addr_src == dest_q) &&
                   (bus_addr_slot[CB_W-1:0] == cb_q);
  assign rsp_hit = bus_addr_valid && !bus_addr_cb &&
                   (bus_addr_slot == my_slot) &&
                   (bus_addr_src == dest_q);

  sbr_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (state_q == ST_WRSP),
    .expire (expire)
  );

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    beat_idx_d = beat_idx_q;
    tmo_d      = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (req_valid) state_d = ST_ARB;
      ST_ARB:   if (arb_grant) state_d = ST_ADDR;
      ST_ADDR:  state_d = ST_CMD;
      ST_CMD: begin
        if (bus_nack)     state_d = ST_WCB;
        else if (write_q) state_d = ST_WDATA;
        else              state_d = ST_WRSP;
      end
      ST_WDATA: state_d = ST_IDLE;
      ST_WCB:   if (cb_hit) state_d = ST_CMD;
      ST_WRSP: begin
        if (rsp_hit) begin
          state_d    = ST_RX;
          beat_idx_d = 1'b0;
        end else if (expire) begin
          state_d = ST_IDLE;
          tmo_d   = 1'b1;
        end
      end
      ST_RX: begin
        beat_idx_d = 1'b1;
        if (!double_q || beat_idx_q) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      beat_idx_q  <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      state_q     <= state_d;
      beat_idx_q  <= beat_idx_d;
      timeout_err <= tmo_d;
    end
  end

  // Request storage, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q  <= 1'b0;
      double_q <= 1'b0;
      dest_q   <= '0;
      cmd_q    <= '0;
      wdata_q  <= '0;
    end else if (accept) begin
      write_q  <= req_write;
      double_q <= req_double;
      dest_q   <= req_dest;
      cmd_q    <= req_cmd;
      wdata_q  <= req_wdata;
    end
  end

  // Callback number, loaded on rejection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cb_q <= '0;
    else if (cb_load) cb_q <= bus_cb_num;
  end

  // Bus drive
  assign req_ready     = (state_q == ST_IDLE);
  assign arb_req       = (state_q == ST_ARB);
  assign addr_drv      = (state_q == ST_ADDR);
  assign addr_slot_out = addr_drv ? dest_q : '0;
  assign addr_src_out  = addr_drv ? my_slot : '0;
  assign data_drv      = (state_q == ST_CMD) || (state_q == ST_WDATA);

  always_comb begin
    data_out = '0;
    if (state_q == ST_CMD)        data_out = cmd_q;
    else if (state_q == ST_WDATA) data_out = wdata_q;
  end

  sbr_parity #(.DATA_W(DATA_W)) u_tx_par (.data(data_out), .par(par_out));

  sbr_rx #(.DATA_W(DATA_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_en    (state_q == ST_RX),
    .beat_data  (bus_data_in),
    .beat_par   (bus_par_in),
    .resp_valid (resp_valid),
    .resp_data  (resp_data),
    .par_err    (par_err)
  );
endmodule

// File: rtl/sbr_requester_chk.sv
module sbr_requester_chk #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              arb_req,
  input logic              arb_grant,
  input logic              addr_drv,
  input logic              data_drv,
  input logic [DATA_W-1:0] data_out,
  input logic [LANES-1:0]  par_out,
  input logic              bus_nack,
  input logic              resp_valid,
  input logic              par_err,
  input logic              timeout_err
);
  logic [LANES-1:0] lane_odd;
  for (genvar g = 0; g < LANES; g++) begin : g_odd
    assign lane_odd[g] = ^{data_out[8*g +: 8], par_out[g]};
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !arb_req && !addr_drv && !data_drv);

  a_r2_take_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> $past(req_valid));

  a_r3_addr_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    arb_req && arb_grant |=> addr_drv);

  a_r4_cmd_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
    addr_drv |=> data_drv);

  a_r5_odd_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    data_drv |-> (lane_odd == {LANES{1'b1}}));

  a_r6_nack_silences: assert property (@(posedge clk) disable iff (!rst_n)
    data_drv && bus_nack && !req_ready |=> !data_drv && !req_ready);

  a_r9_bad_beat_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> !resp_valid);

  a_r10_timeout_frees: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> req_ready);
endmodule

bind sbr_requester sbr_requester_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .arb_req     (arb_req),
  .arb_grant   (arb_grant),
  .addr_drv    (addr_drv),
  .data_drv    (data_drv),
  .data_out    (data_out),
  .par_out     (par_out),
  .bus_nack    (bus_nack),
  .resp_valid  (resp_valid),
  .par_err     (par_err),
  .timeout_err (timeout_err)
);

// File: tb/tb_sbr_requester.sv
module tb_sbr_requester;
  localparam int TMO = 20;
  localparam logic [3:0] ME = 4'd5;

  logic clk, rst_n;
  logic req_valid, req_write, req_double, arb_grant, bus_nack;
  logic bus_addr_valid, bus_addr_cb;
  logic [3:0] req_dest, bus_cb_num, bus_addr_slot, bus_addr_src, bus_par_in;
  logic [31:0] req_cmd, req_wdata, bus_data_in;
  logic req_ready, arb_req, addr_drv, data_drv, resp_valid, par_err, timeout_err;
  logic [3:0] addr_slot_out, addr_src_out, par_out;
  logic [31:0] data_out, resp_data;
  int n_tests, n_fail;

  sbr_requester #(.TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .my_slot(ME),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_double(req_double), .req_dest(req_dest), .req_cmd(req_cmd),
    .req_wdata(req_wdata), .arb_req(arb_req), .arb_grant(arb_grant),
    .addr_drv(addr_drv), .addr_slot_out(addr_slot_out), .addr_src_out(addr_src_out),
    .data_drv(data_drv), .data_out(data_out), .par_out(par_out),
    .bus_nack(bus_nack), .bus_cb_num(bus_cb_num), .bus_addr_valid(bus_addr_valid),
    .bus_addr_cb(bus_addr_cb), .bus_addr_slot(bus_addr_slot), .bus_addr_src(bus_addr_src),
    .bus_data_in(bus_data_in), .bus_par_in(bus_par_in), .resp_valid(resp_valid),
    .resp_data(resp_data), .par_err(par_err), .timeout_err(timeout_err));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [3:0] opar(input logic [31:0] d);
    for (int i = 0; i < 4; i++) opar[i] = ~(^d[8*i +: 8]);
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic addr_phase(input logic cb, input logic [3:0] slot, input logic [3:0] src);
    bus_addr_valid = 1'b1; bus_addr_cb = cb; bus_addr_slot = slot; bus_addr_src = src;
    step();
    bus_addr_valid = 1'b0; bus_addr_cb = 1'b0; bus_addr_slot = '0; bus_addr_src = '0;
  endtask

  // Runs arbitration, address and command cycles; returns at the negedge of the cycle after the command
  task automatic issue(input logic wr, input logic dbl, input logic [3:0] dest,
                       input logic [31:0] cmd, input logic [31:0] wd,
                       input logic nack, input logic [3:0] cbn, input int waits);
    chk("R2 ready before", req_ready, 1);
    req_valid = 1; req_write = wr; req_double = dbl; req_dest = dest; req_cmd = cmd; req_wdata = wd;
    step();
    req_valid = 0;
    for (int w = 0; w < waits; w++) begin
      chk("R3 arb held", arb_req, 1);
      step();
    end
    chk("R3 arb req", arb_req, 1);
    chk("R2 busy", req_ready, 0);
    arb_grant = 1;
    step();
    arb_grant = 0;
    chk("R3 addr", {addr_drv, addr_slot_out, addr_src_out}, {1'b1, dest, ME});
    step();
    chk("R4 cmd beat", {data_drv, data_out}, {1'b1, cmd});
    chk("R5 cmd parity", par_out, opar(cmd));
    bus_nack = nack; bus_cb_num = cbn;
    step();
    bus_nack = 0; bus_cb_num = '0;
  endtask

  task automatic wdata_tail(input logic [31:0] wd);
    chk("R4 wdata beat", {data_drv, data_out}, {1'b1, wd});
    chk("R5 wdata parity", par_out, opar(wd));
    step();
    chk("R4 idle after write", {req_ready, data_drv}, 2'b10);
  endtask

  task automatic callback(input logic [3:0] dest, input logic [3:0] cbn, input logic [31:0] cmd);
    chk("R6 silent after nack", {data_drv, req_ready, addr_drv}, 3'b000);
    // busy-time request that must be ignored (R11)
    req_valid = 1; req_cmd = ~cmd; req_dest = dest ^ 4'h3;
    addr_phase(1'b1, cbn, dest ^ 4'h1);
    chk("R7 wrong src ignored", data_drv, 0);
    addr_phase(1'b1, cbn ^ 4'h1, dest);
    chk("R7 wrong number ignored", data_drv, 0);
    addr_phase(1'b0, cbn, dest);
    chk("R7 non-callback ignored", data_drv, 0);
    req_valid = 0;
    addr_phase(1'b1, cbn, dest);
    chk("R7 R11 replay cmd", {data_drv, data_out}, {1'b1, cmd});
    chk("R5 replay parity", par_out, opar(cmd));
    step();
  endtask

  task automatic response(input logic [3:0] dest, input logic dbl,
                          input logic [31:0] d0, input logic [31:0] d1, input logic bad);
    chk("R8 no drive in wait", {data_drv, req_ready}, 2'b00);
    addr_phase(1'b0, ME ^ 4'h2, dest);
    chk("R8 other slot ignored", resp_valid, 0);
    addr_phase(1'b0, ME, dest);
    bus_data_in = d0; bus_par_in = opar(d0) ^ {3'b000, bad};
    step();
    if (bad) chk("R9 bad beat", {par_err, resp_valid}, 2'b10);
    else     chk("R8 beat0", {resp_valid, par_err, resp_data}, {2'b10, d0});
    if (dbl) begin
      bus_data_in = d1; bus_par_in = opar(d1);
      step();
      chk("R8 beat1", {resp_valid, par_err, resp_data}, {2'b10, d1});
    end
    bus_data_in = '0; bus_par_in = '0;
    chk("R2 ready after response", req_ready, 1);
    step();
    chk("R8 no extra beat", resp_valid, 0);
  endtask

  initial begin
    n_tests = 0; n_fail = 0;
    rst_n = 0; req_valid = 0; req_write = 0; req_double = 0; req_dest = '0;
    req_cmd = '0; req_wdata = '0; arb_grant = 0; bus_nack = 0; bus_cb_num = '0;
    bus_addr_valid = 0; bus_addr_cb = 0; bus_addr_slot = '0; bus_addr_src = '0;
    bus_data_in = '0; bus_par_in = '0;
    step(); step();
    rst_n = 1;
    step();
    chk("R1 reset state", {req_ready, arb_req, addr_drv, data_drv, resp_valid, par_err, timeout_err},
        7'b1000000);

    // Writes to every slot, alternating rejection, varying grant delay
    for (int s = 0; s < 16; s++) begin
      logic [31:0] c, w;
      logic [3:0] cb;
      c = 32'h1000_0000 + s * 32'h0101_0103;
      w = 32'hA5A5_0000 ^ (s * 32'h0011_2233);
      cb = 4'(s) ^ 4'hA;
      issue(1'b1, 1'b0, 4'(s), c, w, s[0], cb, s % 3);
      if (s[0]) callback(4'(s), cb, c);
      wdata_tail(w);
    end

    // Reads: single/double, with and without rejection, one parity error
    for (int k = 0; k < 8; k++) begin
      logic [3:0] d;
      d = 4'(k * 3 + 1);
      issue(1'b0, k[0], d, 32'h8000_0000 | k, '0, k[1], 4'(k), 0);
      if (k[1]) callback(d, 4'(k), 32'h8000_0000 | k);
      response(d, k[0], 32'hC0DE_0000 + k * 32'h0107_0301, 32'h7E57_0000 ^ k, k == 4);
    end

    // Timeout on a read that is never answered
    begin
      int cnt;
      issue(1'b0, 1'b0, 4'd9, 32'h8765_4321, '0, 1'b0, '0, 0);
      cnt = 0;
      while (!timeout_err && cnt < 4 * TMO) begin
        step();
        cnt++;
      end
      chk("R10 timeout delay", cnt, TMO);
      chk("R10 ready with timeout", req_ready, 1);
      step();
      chk("R10 single pulse", timeout_err, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule